// File: doc/BRIEF.md
# Aliased Control Register with Secure and Non-Secure Access Windows

This block holds the single physical control register of a random-number generator and exposes it to software through two address windows. A secure-world window always reaches the register. A non-secure-world window reaches the same register only when a 4-bit key field inside the register holds 0xA and a separate enable bit grants non-secure control access. Each world also has its own status window. The status window reports the available data level and the error flag of that world's output queue. The data queues and the entropy path sit outside the block and feed these status inputs.

Software reaches the block through a small request/response register bus. Each request carries a word address, a write flag, write data and a secure attribute. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request, read or write, produces exactly one response one cycle later, and responses come back in request order. A response stays on `rsp_valid`, `rsp_data` and `rsp_denied`, unchanged, until `rsp_ready` is high at a clock edge. While a response waits with `rsp_ready` low, `req_ready` is low, so at most one request is in flight. A blocked access has no side effect except on a sticky violation flag. Its response returns zero data with `rsp_denied` set.

The reset value of the register enables the oscillator and both health tests, so the generator runs with no programming. The key field resets to 0x5, so non-secure access is closed after reset.

Top module: `sw_access_window`

## Requirements
- R1: After reset the control register reads 0x0000_0535. Its fields are: bit 0 oscillator enable = 1, bits 3:1 oscillator divider = 2, bit 4 repetition-count test enable = 1, bit 5 proportion test enable = 1, bit 6 non-secure control grant = 0, bits 11:8 key = 0x5. Also after reset `ns_open` is 0 and `violation` is 0.
- R2: Word addresses are 0 (secure control), 1 (secure status), 2 (non-secure control) and 3 (non-secure status). A request with `req_secure`=1 to address 0 always reads the control register. A write there stores `req_wdata & 0x0000_0F7F`, and the other bits read as zero.
- R3: A request with `req_secure`=0 to address 3 is allowed only while the key equals 0xA. `ns_open` is high exactly when the key equals 0xA.
- R4: A request with `req_secure`=0 to address 2 is allowed only while the key equals 0xA and bit 6 is 1. It reads and writes the same physical register as address 0.
- R5: A blocked write leaves the register unchanged. A blocked read or write returns `rsp_data`=0 with `rsp_denied`=1. An allowed access returns `rsp_denied`=0, and an allowed write returns data 0.
- R6: A request with `req_secure`=0 to address 0 or 1 is always blocked.
- R7: Any blocked access sets the sticky `violation` flag, which reads as bit 31 of the secure status word. A secure write to address 1 with bit 31 set clears it. Nothing else clears it except reset.
- R8: The secure status word is {violation[31], err_s[16], s_level[8:0]}. The non-secure status word is {err_ns[16], ns_level[8:0]}. All other bits are zero.
- R9: Exactly one response follows each accepted request, one cycle after acceptance, in order. While `rsp_valid`=1 and `rsp_ready`=0, the response is held stable and `req_ready` is 0.
- R10: A request with `req_secure`=1 to address 2 or 3 is always allowed, whatever the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 2 | Word address of the window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Secure attribute of the request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 32 | Read data, zero for writes and blocked accesses |
| rsp_denied | output | 1 | Access was blocked |
| s_level | input | 9 | Secure queue available level |
| err_s | input | 1 | Secure-side error flag |
| ns_level | input | 9 | Non-secure queue available level |
| err_ns | input | 1 | Non-secure-side error flag |
| cfg_osc_en | output | 1 | Oscillator enable field |
| cfg_osc_div | output | 3 | Oscillator divider field |
| cfg_rct_en | output | 1 | Repetition-count test enable field |
| cfg_apt_en | output | 1 | Proportion test enable field |
| ns_open | output | 1 | Key equals 0xA |
| violation | output | 1 | Sticky blocked-access flag |

## Verification
A wrong permission decision shows on the very next response as a nonzero value where zero was due, or as a flipped `rsp_denied`. When such an access was a write, the damage to the register shows on the configuration pins in that same cycle and on every later read of either control alias. A wrong violation state shows on the `violation` pin one cycle after the blocked access, and in the next secure status read. Handshake faults show as a lost, duplicated or changed response, which the in-order scoreboard detects at the next pop.

// File: rtl/sw_access_pkg.sv
package sw_access_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int LVL_W   = 9;
  localparam int KEY_W   = 4;
  localparam int KEY_LSB = 8;
  localparam logic [KEY_W-1:0]  KEY_OPEN   = 4'hA;
  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0535;
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0000_0F7F;
  localparam int BIT_OSC_EN  = 0;
  localparam int BIT_DIV_LSB = 1;
  localparam int BIT_RCT_EN  = 4;
  localparam int BIT_APT_EN  = 5;
  localparam int BIT_NS_CTRL = 6;
  localparam int BIT_ERR     = 16;
  localparam int BIT_VIOL    = 31;

  typedef enum logic [ADDR_W-1:0] {
    WIN_CTRL_S  = 2'd0,
    WIN_STAT_S  = 2'd1,
    WIN_CTRL_NS = 2'd2,
    WIN_STAT_NS = 2'd3
  } win_e;
endpackage

// File: rtl/sw_access_gate.sv
module sw_access_gate
  import sw_access_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              secure,
  input  logic [KEY_W-1:0]  key,
  input  logic              ns_ctrl_grant,
  output win_e              win,
  output logic              allow,
  output logic              key_open
);
  always_comb begin
    win      = win_e'(addr);
    key_open = (key == KEY_OPEN);
    if (secure) begin
      allow = 1'b1;
    end else begin
      unique case (win)
        WIN_CTRL_S, WIN_STAT_S: allow = 1'b0;
        WIN_CTRL_NS:            allow = key_open && ns_ctrl_grant;
        WIN_STAT_NS:            allow = key_open;
        default:                allow = 1'b0;
      endcase
    end
  end

  assert_ns_secure_win_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure && !addr[1]) |-> !allow);
  assert_ns_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure && allow) |-> (key == KEY_OPEN));
  assert_secure_any_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
    secure |-> allow);
endmodule

// File: rtl/sw_ctrl_reg.sv
module sw_ctrl_reg
  import sw_access_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              is_wr,
  input  logic              allow,
  input  win_e              win,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              viol_q
);
  logic ctrl_we;
  logic viol_clr;

  assign ctrl_we  = acc && is_wr && allow && (win == WIN_CTRL_S || win == WIN_CTRL_NS);
  assign viol_clr = acc && is_wr && allow && (win == WIN_STAT_S) && wdata[BIT_VIOL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (ctrl_we) begin
      ctrl_q <= wdata & CTRL_WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
    end else if (acc && !allow) begin
      viol_q <= 1'b1;
    end else if (viol_clr) begin
      viol_q <= 1'b0;
    end
  end

  assert_blocked_write_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_wr && !allow) |=> $stable(ctrl_q));
  assert_blocked_sets_violation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !allow) |=> viol_q);
  assert_reserved_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_WMASK) == '0);
endmodule

// File: rtl/sw_resp_stage.sv
module sw_resp_stage
  import sw_access_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              allow,
  input  logic              is_wr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rsp_ready,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_denied
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_denied <= 1'b0;
    end else if (acc) begin
      rsp_valid  <= 1'b1;
      rsp_data   <= (allow && !is_wr) ? rd_data : '0;
      rsp_denied <= !allow;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_denied)));
  assert_no_accept_while_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !acc);
  assert_denied_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !allow) |=> (rsp_denied && rsp_data == '0));
endmodule

// File: rtl/sw_access_window.sv
module sw_access_window
  import sw_access_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_addr,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic              req_secure,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_denied,
  input  logic [8:0]        s_level,
  input  logic              err_s,
  input  logic [8:0]        ns_level,
  input  logic              err_ns,
  output logic              cfg_osc_en,
  output logic [2:0]        cfg_osc_div,
  output logic              cfg_rct_en,
  output logic              cfg_apt_en,
  output logic              ns_open,
  output logic              violation
);
  logic [DATA_W-1:0] ctrl_q;
  logic              viol_q;
  logic              allow;
  logic              key_open;
  win_e              win;
  logic              acc;
  logic [DATA_W-1:0] rd_data;

  assign acc = req_valid && req_ready;

  sw_access_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (req_addr),
    .secure       (req_secure),
    .key          (ctrl_q[KEY_LSB +: KEY_W]),
    .ns_ctrl_grant(ctrl_q[BIT_NS_CTRL]),
    .win          (win),
    .allow        (allow),
    .key_open     (key_open)
  );

  sw_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .is_wr (req_write),
    .allow (allow),
    .win   (win),
    .wdata (req_wdata),
    .ctrl_q(ctrl_q),
    .viol_q(viol_q)
  );

  always_comb begin
    rd_data = '0;
    unique case (win)
      WIN_CTRL_S, WIN_CTRL_NS: rd_data = ctrl_q;
      WIN_STAT_S: begin
        rd_data[LVL_W-1:0] = s_level;
        rd_data[BIT_ERR]   = err_s;
        rd_data[BIT_VIOL]  = viol_q;
      end
      WIN_STAT_NS: begin
        rd_data[LVL_W-1:0] = ns_level;
        rd_data[BIT_ERR]   = err_ns;
      end
      default: rd_data = '0;
    endcase
  end

  sw_resp_stage u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .allow     (allow),
    .is_wr     (req_write),
    .rd_data   (rd_data),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_denied(rsp_denied)
  );

  assign cfg_osc_en  = ctrl_q[BIT_OSC_EN];
  assign cfg_osc_div = ctrl_q[BIT_DIV_LSB +: 3];
  assign cfg_rct_en  = ctrl_q[BIT_RCT_EN];
  assign cfg_apt_en  = ctrl_q[BIT_APT_EN];
  assign ns_open     = key_open;
  assign violation   = viol_q;

  assert_ns_status_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_secure && req_addr == 2'd3 && !ns_open) |=> rsp_denied);
  assert_ns_ctrl_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_secure && req_addr == 2'd2 && !ctrl_q[BIT_NS_CTRL]) |=> rsp_denied);
endmodule

// File: tb/test_sw_access_window.sv
module test_sw_access_window;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_denied;
  logic [31:0] rsp_data;
  logic [8:0] s_level = 9'h100, ns_level = 9'h080;
  logic err_s = 1'b1, err_ns = 1'b0;
  logic cfg_osc_en, cfg_rct_en, cfg_apt_en, ns_open, violation;
  logic [2:0] cfg_osc_div;

  int checks = 0, errors = 0, cyc = 0;
  bit bp_mode = 0;
  logic [31:0] ctrl_m = 32'h0000_0535;
  bit viol_m = 0;
  logic [32:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  sw_access_window i_sw_access_window (.*);

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO-less FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_s_word();
    return {viol_m, 14'd0, err_s, 7'd0, s_level};
  endfunction

  // Driver: called at a negedge; pushes the expected response from the requirement model.
  task automatic access(input string tag, input logic [1:0] a, input bit sec,
                        input bit wr, input logic [31:0] wd);
    bit ok;
    logic [31:0] ed;
    req_valid = 1'b1; req_addr = a; req_secure = sec; req_write = wr; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (sec) ok = 1;
    else if (a == 2'd3) ok = (ctrl_m[11:8] == 4'hA);
    else if (a == 2'd2) ok = (ctrl_m[11:8] == 4'hA) && ctrl_m[6];
    else ok = 0;
    ed = 32'd0;
    if (ok && !wr) begin
      case (a)
        2'd0, 2'd2: ed = ctrl_m;
        2'd1: ed = stat_s_word();
        default: ed = {15'd0, err_ns, 7'd0, ns_level};
      endcase
    end
    if (!ok) viol_m = 1;
    else if (wr && (a == 2'd0 || a == 2'd2)) ctrl_m = wd & 32'h0000_0F7F;
    else if (wr && a == 2'd1 && wd[31]) viol_m = 0;
    exp_q.push_back({!ok, ed});
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk); #2;
  endtask

  // Monitor: pops the scoreboard when a response handshake will happen.
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (rst_n && rsp_valid) begin
        if (rsp_ready) begin
          if (exp_q.size() == 0) begin
            chk("R9 unexpected response", 33'd1, 33'd0);
          end else begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {rsp_denied, rsp_data}, e);
          end
        end else begin
          chk("R9 req_ready low while stalled", {32'd0, req_ready}, 33'd0);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 reset cfg pins", {26'd0, cfg_osc_en, cfg_osc_div, cfg_rct_en, cfg_apt_en, ns_open, violation},
        {26'd0, 1'b1, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0});
    @(negedge clk);
    access("R1 R2 secure ctrl reset read", 2'd0, 1, 0, 0);
    access("R3 ns status denied after reset", 2'd3, 0, 0, 0);
    access("R7 R8 secure status shows violation", 2'd1, 1, 0, 0);
    drain();
    chk("R7 violation pin set", {32'd0, violation}, 33'd1);
    @(negedge clk);
    access("R7 secure w1c status", 2'd1, 1, 1, 32'h8000_0000);
    access("R7 violation cleared in status", 2'd1, 1, 0, 0);
    access("R4 R5 ns ctrl write blocked", 2'd2, 0, 1, 32'h0000_FFFF);
    access("R5 ctrl unchanged after blocked write", 2'd0, 1, 0, 0);
    access("R6 ns attr on secure ctrl addr", 2'd0, 0, 0, 0);
    access("R6 ns attr write on secure ctrl addr", 2'd0, 0, 1, 32'h0000_0A7F);
    access("R6 ns attr on secure status addr", 2'd1, 0, 0, 0);
    access("R2 secure write opens key", 2'd0, 1, 1, 32'h0000_0A35);
    drain();
    chk("R3 ns_open pin", {32'd0, ns_open}, 33'd1);
    @(negedge clk);
    access("R3 R8 ns status allowed with key", 2'd3, 0, 0, 0);
    access("R4 ns ctrl denied without grant", 2'd2, 0, 0, 0);
    access("R2 secure write masked", 2'd0, 1, 1, 32'hFFFF_FA75);
    access("R2 masked value readback", 2'd0, 1, 0, 0);
    access("R4 ns ctrl alias read", 2'd2, 0, 0, 0);
    access("R4 ns ctrl alias write", 2'd2, 0, 1, 32'h0000_0A0C);
    drain();
    chk("R4 cfg pins after ns write", {29'd0, cfg_osc_en, cfg_rct_en, cfg_apt_en, cfg_osc_div},
        {29'd0, 1'b0, 1'b0, 1'b0, 3'd6});
    @(negedge clk);
    access("R4 secure sees ns write", 2'd0, 1, 0, 0);
    access("R4 ns ctrl denied after grant cleared", 2'd2, 0, 0, 0);
    access("R2 secure closes key", 2'd0, 1, 1, 32'h0000_0535);
    access("R10 secure reads ns status", 2'd3, 1, 0, 0);
    access("R10 secure reads ns ctrl", 2'd2, 1, 0, 0);
    access("R3 ns status denied after close", 2'd3, 0, 0, 0);
    bp_mode = 1;
    for (int i = 0; i < 12; i++) begin
      access("R9 backpressure status read", 2'd1, 1, 0, 0);
      access("R9 backpressure ctrl read", 2'd0, 1, 0, 0);
    end
    bp_mode = 0;
    access("R7 final status", 2'd1, 1, 0, 0);
    drain();
    chk("R9 scoreboard empty", {32'd0, exp_q.size() != 0}, 33'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule